// File: doc/BRIEF.md
# Fault Status Latch and Alert Generator

This block sits behind the comparators and the sampling logic of a supply-monitoring front end. It takes one-cycle event pulses from twelve named fault and warning sources and holds each one in a sticky status bit until software clears it. One shared output pin reports these bits. Each status bit has its own enable in a configuration word, and the pin goes low while any enabled bit is set.

The same pin can be set to one of three roles. In alert mode it drives the masked, active-low alert. In general-purpose output mode it drives a level chosen by software. In conversion mode the pin is an input, and its level is passed to the sampling logic as a start-of-conversion request. A write port sets the enables, the pin role, the general-purpose level, the fault-timer terminal count and clear masks. A write is carried out only when its packet error check has passed.

A small timer watches the current-limit input. The "limiting active" status bit is set on the first cycle of limiting. The overcurrent fault bit is set only after limiting has lasted without a break for the programmed number of cycles.

Top module: `fault_alert_ctrl`

## Requirements
- R1: After synchronous reset, all status bits are 0, the pin output is 1, the pin output enable is 1, the conversion output is 0 and the enables equal 0x8000. Only source 11 (FET health bad) is enabled.
- R2: A 1 on `evt_i[k]` at a clock edge sets `status_o[k]` at that edge. The bit then stays 1, with no event present, until a clear write selects it. Source indices are: 11 FET health bad, 10 output overcurrent fault, 9 input overvoltage fault, 8 input undervoltage fault, 7 communication error, 6 overcurrent warning, 5 second current warning, 4 input overvoltage warning, 3 input undervoltage warning, 2 auxiliary overvoltage warning, 1 auxiliary undervoltage warning, 0 current limiting active.
- R3: In alert mode (`00`), `pin_o` is 0 one clock after any status bit k is set while enable bit k+4 of the configuration word is 1. Otherwise `pin_o` is 1.
- R4: A status bit whose enable is 0 stays latched but does not pull `pin_o` low.
- R5: A write of mask M to address 2 clears the status bits selected by M[11:0]. If an event for a bit occurs in the same cycle as its clear, the bit stays set.
- R6: `limit_i` sampled high sets status bit 0 at that edge. Status bit 10 sets at the edge where `limit_i` has been high for the terminal count of consecutive edges. If `limit_i` drops earlier, the count restarts from zero.
- R7: A write with `wr_pec_ok` = 0 changes no setting and sets status bit 7.
- R8: In general-purpose mode (`01`), `pin_o` equals the written level (pin-control bit 2) one clock after the setting, whatever the status bits and enables are.
- R9: In conversion mode (`10`), `pin_oe_o` is 0, `pin_o` is 1, and `conv_o` follows `pin_i` with one clock of delay. In every other mode, `conv_o` is 0.
- R10: Pin mode `11` behaves exactly as alert mode.
- R11: The write addresses are 0 for the configuration word (enables in bits 15..4), 1 for pin control (bits 1..0 mode, bit 2 level), 2 for the clear mask and 3 for the timer terminal count. A setting takes effect at the edge of the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 12 | One-cycle event pulses, one per source |
| limit_i | input | 1 | Current limiting active |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 16 | Register write data |
| wr_pec_ok | input | 1 | Packet error check of the write passed |
| pin_i | input | 1 | Level seen on the shared pin |
| status_o | output | 12 | Latched status bits |
| pin_o | output | 1 | Level driven onto the shared pin |
| pin_oe_o | output | 1 | Pin output enable |
| conv_o | output | 1 | Conversion-start request to the sampling logic |

## Verification
Two functions of this block can act on one status bit in the same cycle: a source event sets the bit while a clear write removes it. The bench raises source 9 and writes a clear mask for bit 9 on the same clock edge. It expects the bit to still read 1 afterwards, and only a later clear with no event present brings it to 0. A second collision happens in the timer. The same run of `limit_i` sets bit 0 at once, and that run either reaches or falls short of the terminal count. The bench judges bit 10 one edge before and exactly at the terminal count.

// File: rtl/fault_alert_pkg.sv
package fault_alert_pkg;
  localparam int NSRC = 12;

  localparam int SRC_FET_BAD  = 11;
  localparam int SRC_OC_FAULT = 10;
  localparam int SRC_VIN_OV_F = 9;
  localparam int SRC_VIN_UV_F = 8;
  localparam int SRC_COMM_ERR = 7;
  localparam int SRC_OC_WARN  = 6;
  localparam int SRC_I_WARN2  = 5;
  localparam int SRC_VIN_OV_W = 4;
  localparam int SRC_VIN_UV_W = 3;
  localparam int SRC_AUX_OV_W = 2;
  localparam int SRC_AUX_UV_W = 1;
  localparam int SRC_INLIM    = 0;

  typedef enum logic [1:0] {
    MODE_ALERT = 2'b00,
    MODE_GPO   = 2'b01,
    MODE_CONV  = 2'b10,
    MODE_RSVD  = 2'b11
  } pin_mode_e;

  localparam logic [1:0] ADR_CFG = 2'd0;
  localparam logic [1:0] ADR_PIN = 2'd1;
  localparam logic [1:0] ADR_CLR = 2'd2;
  localparam logic [1:0] ADR_TMR = 2'd3;
endpackage

// File: rtl/fa_regs.sv
module fa_regs
  import fault_alert_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 2,
  parameter int TMR_W = 16,
  parameter int TMR_INIT = 8,
  parameter logic [DATA_W-1:0] CFG_RESET = 16'h8000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_pec_ok,
  output logic [NSRC-1:0]   en_q,
  output pin_mode_e         mode_q,
  output logic              gpo_q,
  output logic [TMR_W-1:0]  tc_q,
  output logic [NSRC-1:0]   clr_mask,
  output logic              pec_err
);
  localparam int EN_LSB = DATA_W - NSRC;

  logic wr_ok;
  assign wr_ok    = wr_en & wr_pec_ok;
  assign pec_err  = wr_en & ~wr_pec_ok;
  assign clr_mask = (wr_ok && wr_addr == ADDR_W'(ADR_CLR)) ? wr_data[NSRC-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= CFG_RESET[DATA_W-1:EN_LSB];
      mode_q <= MODE_ALERT;
      gpo_q  <= 1'b1;
      tc_q   <= TMR_W'(TMR_INIT);
    end else if (wr_ok) begin
      if (wr_addr == ADDR_W'(ADR_CFG)) en_q <= wr_data[DATA_W-1:EN_LSB];
      if (wr_addr == ADDR_W'(ADR_PIN)) begin
        mode_q <= pin_mode_e'(wr_data[1:0]);
        gpo_q  <= wr_data[2];
      end
      if (wr_addr == ADDR_W'(ADR_TMR)) tc_q <= wr_data[TMR_W-1:0];
    end
  end
endmodule

// File: rtl/fa_fault_timer.sv
module fa_fault_timer #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             limit_i,
  input  logic [TMR_W-1:0] tc_i,
  output logic             expire_o
);
  logic [TMR_W-1:0] cnt;
  logic [TMR_W-1:0] cnt_inc;

  assign cnt_inc  = cnt + TMR_W'(1);
  // One pulse on the edge where the run of limiting reaches the terminal count
  assign expire_o = limit_i && (cnt_inc == tc_i) && (cnt != tc_i);

  always_ff @(posedge clk) begin
    if (rst || !limit_i) cnt <= '0;
    else if (cnt != tc_i) cnt <= cnt_inc;
  end
endmodule

// File: rtl/fa_status_bank.sv
module fa_status_bank
  import fault_alert_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] status_o
);
  for (genvar k = 0; k < NSRC; k++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)           status_o[k] <= 1'b0;
      else if (set_i[k]) status_o[k] <= 1'b1;   // set has priority over clear
      else if (clr_i[k]) status_o[k] <= 1'b0;
    end
  end
endmodule

// File: rtl/fa_pin_mux.sv
module fa_pin_mux
  import fault_alert_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  pin_mode_e       mode_i,
  input  logic            gpo_i,
  input  logic [NSRC-1:0] status_i,
  input  logic [NSRC-1:0] en_i,
  input  logic            pin_i,
  output logic            pin_o,
  output logic            pin_oe_o,
  output logic            conv_o
);
  logic alert_n, pin_d, oe_d, conv_d;

  assign alert_n = ~|(status_i & en_i);

  always_comb begin
    pin_d  = alert_n;
    oe_d   = 1'b1;
    conv_d = 1'b0;
    case (mode_i)
      MODE_GPO:  pin_d = gpo_i;
      MODE_CONV: begin
        pin_d  = 1'b1;
        oe_d   = 1'b0;
        conv_d = pin_i;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_o    <= 1'b1;
      pin_oe_o <= 1'b1;
      conv_o   <= 1'b0;
    end else begin
      pin_o    <= pin_d;
      pin_oe_o <= oe_d;
      conv_o   <= conv_d;
    end
  end
endmodule

// File: rtl/fault_alert_ctrl.sv
module fault_alert_ctrl
  import fault_alert_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 2,
  parameter int TMR_W = 16,
  parameter int TMR_INIT = 8,
  parameter logic [DATA_W-1:0] CFG_RESET = 16'h8000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   evt_i,
  input  logic              limit_i,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_pec_ok,
  input  logic              pin_i,
  output logic [NSRC-1:0]   status_o,
  output logic              pin_o,
  output logic              pin_oe_o,
  output logic              conv_o
);
  logic [NSRC-1:0]  en_q, clr_mask, set_vec;
  pin_mode_e        mode_q;
  logic             gpo_q, pec_err, oc_expire;
  logic [TMR_W-1:0] tc_q;

  fa_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .TMR_W(TMR_W),
    .TMR_INIT(TMR_INIT), .CFG_RESET(CFG_RESET)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_pec_ok(wr_pec_ok), .en_q(en_q),
    .mode_q(mode_q), .gpo_q(gpo_q), .tc_q(tc_q),
    .clr_mask(clr_mask), .pec_err(pec_err)
  );

  fa_fault_timer #(.TMR_W(TMR_W)) u_timer (
    .clk(clk), .rst(rst), .limit_i(limit_i), .tc_i(tc_q), .expire_o(oc_expire)
  );

  always_comb begin
    set_vec               = evt_i;
    set_vec[SRC_OC_FAULT] = evt_i[SRC_OC_FAULT] | oc_expire;
    set_vec[SRC_INLIM]    = evt_i[SRC_INLIM] | limit_i;
    set_vec[SRC_COMM_ERR] = evt_i[SRC_COMM_ERR] | pec_err;
  end

  fa_status_bank u_status (
    .clk(clk), .rst(rst), .set_i(set_vec), .clr_i(clr_mask), .status_o(status_o)
  );

  fa_pin_mux u_pin (
    .clk(clk), .rst(rst), .mode_i(mode_q), .gpo_i(gpo_q),
    .status_i(status_o), .en_i(en_q), .pin_i(pin_i),
    .pin_o(pin_o), .pin_oe_o(pin_oe_o), .conv_o(conv_o)
  );
endmodule

// File: rtl/fault_alert_chk.sv
module fault_alert_chk #(
  parameter int NS = 12,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              limit_i,
  input logic              wr_en,
  input logic              wr_pec_ok,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [NS-1:0]     status_o,
  input logic              pin_o,
  input logic              pin_oe_o,
  input logic [NS-1:0]     en_q,
  input logic [1:0]        mode_q,
  input logic              gpo_q
);
  // R2: without a clear write, no latched bit falls
  a_r2_sticky: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_pec_ok && wr_addr == ADDR_W'(2))
    |=> ((status_o & $past(status_o)) == $past(status_o)));

  // R3 / R10: an enabled set bit pulls the pin low in the alert roles
  a_r3_alert_low: assert property (@(posedge clk) disable iff (rst)
    ((mode_q == 2'b00 || mode_q == 2'b11) && |(status_o & en_q)) |=> !pin_o);

  // R6: limiting sets its status bit on the same edge
  a_r6_inlim_set: assert property (@(posedge clk) disable iff (rst)
    limit_i |=> status_o[0]);

  // R7: a failed check sets the communication error bit
  a_r7_pec_flag: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_pec_ok) |=> status_o[7]);

  // R8: general-purpose role drives the software level
  a_r8_gpo_level: assert property (@(posedge clk) disable iff (rst)
    (mode_q == 2'b01) |=> (pin_o == $past(gpo_q)));

  // R9: conversion role releases the pin
  a_r9_conv_release: assert property (@(posedge clk) disable iff (rst)
    (mode_q == 2'b10) |=> (!pin_oe_o && pin_o));
endmodule

bind fault_alert_ctrl fault_alert_chk #(.NS(fault_alert_pkg::NSRC), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .limit_i(limit_i), .wr_en(wr_en), .wr_pec_ok(wr_pec_ok),
  .wr_addr(wr_addr), .status_o(status_o), .pin_o(pin_o), .pin_oe_o(pin_oe_o),
  .en_q(en_q), .mode_q(mode_q), .gpo_q(gpo_q)
);

// File: tb/fault_alert_ctrl_bench.sv
`timescale 1ns/100ps
module fault_alert_ctrl_bench;
  localparam int K_ST = 0, K_PIN = 1, K_OE = 2, K_CONV = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] evt_i = '0;
  logic        limit_i = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        wr_pec_ok = 1'b1;
  logic        pin_i = 1'b0;
  logic [11:0] status_o;
  logic        pin_o, pin_oe_o, conv_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  typedef struct {
    string       tag;
    int          kind;
    logic [11:0] val;
  } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  fault_alert_ctrl u_fault_alert_ctrl (
    .clk(clk), .rst(rst), .evt_i(evt_i), .limit_i(limit_i), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_pec_ok(wr_pec_ok), .pin_i(pin_i),
    .status_o(status_o), .pin_o(pin_o), .pin_oe_o(pin_oe_o), .conv_o(conv_o)
  );

  // Monitor: compare every queued expectation at the falling edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      exp_t it;
      logic [11:0] act;
      it = q.pop_front();
      case (it.kind)
        K_ST:    act = status_o;
        K_PIN:   act = {11'd0, pin_o};
        K_OE:    act = {11'd0, pin_oe_o};
        default: act = {11'd0, conv_o};
      endcase
      checks++;
      if (act !== it.val) begin
        fails++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.val);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic push(string tag, int kind, logic [11:0] val);
    exp_t it;
    it.tag = tag; it.kind = kind; it.val = val;
    q.push_back(it);
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d, logic ok = 1'b1);
    wr_en = 1'b1; wr_addr = a; wr_data = d; wr_pec_ok = ok;
    tick();
    wr_en = 1'b0; wr_pec_ok = 1'b1;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    // R1 reset state
    push("R1", K_ST, 12'h000); push("R1", K_PIN, 1); push("R1", K_OE, 1); push("R1", K_CONV, 0);
    tick();

    // R2 / R3: FET health event, enabled at reset
    evt_i = 12'h800; tick(); evt_i = '0;
    push("R2", K_ST, 12'h800); push("R3", K_PIN, 1);
    tick(); push("R3", K_PIN, 0);
    tick(); tick(); push("R2", K_ST, 12'h800);

    // R5 clear
    wr(2'd2, 16'h0800); push("R5", K_ST, 12'h000);
    tick(); push("R5", K_PIN, 1);

    // R4 disabled source latches but no alert
    evt_i = 12'h200; tick(); evt_i = '0;
    push("R2", K_ST, 12'h200);
    tick(); tick(); push("R4", K_PIN, 1);
    // R11 enable source 9 via config bit 13
    wr(2'd0, 16'h2000); push("R11", K_PIN, 1);
    tick(); push("R11", K_PIN, 0);

    // R5 set wins over a clear on the same edge
    evt_i = 12'h200; wr_en = 1'b1; wr_addr = 2'd2; wr_data = 16'h0200;
    tick(); evt_i = '0; wr_en = 1'b0;
    push("R5", K_ST, 12'h200);
    wr(2'd2, 16'h0FFF); push("R5", K_ST, 12'h000);
    tick(); push("R5", K_PIN, 1);

    // R6 fault timer with terminal count 4
    wr(2'd3, 16'd4);
    limit_i = 1'b1; tick(); push("R6", K_ST, 12'h001);
    tick(); tick(); limit_i = 1'b0; push("R6", K_ST, 12'h001);
    tick();
    limit_i = 1'b1; tick(); tick(); tick(); push("R6", K_ST, 12'h001);
    tick(); push("R6", K_ST, 12'h401);
    limit_i = 1'b0; tick();
    wr(2'd2, 16'h0FFF); push("R6", K_ST, 12'h000);

    // R7 bad check: config not taken, comm error set
    wr(2'd0, 16'hFFF0, 1'b0); push("R7", K_ST, 12'h080);
    tick(); tick(); push("R7", K_PIN, 1);

    // R11 full enable, comm error now alerts
    wr(2'd0, 16'hFFF0); tick(); push("R11", K_PIN, 0);

    // R8 general-purpose level overrides the alert
    pin_i = 1'b1;
    wr(2'd1, 16'h0005); tick(); push("R8", K_PIN, 1); push("R9", K_CONV, 0);
    wr(2'd1, 16'h0001); tick(); push("R8", K_PIN, 0);

    // R9 conversion role
    wr(2'd1, 16'h0002); tick();
    push("R9", K_OE, 0); push("R9", K_PIN, 1); push("R9", K_CONV, 1);
    pin_i = 1'b0; tick(); push("R9", K_CONV, 0);

    // R10 reserved role acts as alert
    wr(2'd1, 16'h0003); tick(); push("R10", K_PIN, 0); push("R10", K_OE, 1);
    wr(2'd2, 16'h0FFF); tick(); push("R10", K_PIN, 1);

    tick();
    done = 1;
    finish_run();
  end
endmodule